// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Scheduler

This block paces periodic refresh requests for one DRAM device. A programmable base count sets the request interval for the normal thermal range. A case-temperature reading from the on-die sensor moves the scheduler into a high-temperature range in which the retention window halves, so requests come twice as often. A two-degree hysteresis band stops the rate from toggling near the threshold. A reading beyond the device's rated maximum raises an alarm, and the fast rate stays in force.

Refresh requests go to the command arbiter over a valid/ready pair. `ref_req` is valid and `ref_grant` is ready. A request stays raised until it is granted, so the arbiter can hold off refreshes. Intervals that pass without a grant build up as a postponed-refresh debt of at most eight, and further intervals beyond that limit are lost. A grant presented while no request is raised has no effect. In all-bank mode each granted request covers every bank at once. In same-bank mode each request covers one bank index, the interval is divided by the bank count so that one full window still reaches every bank, and the index advances on every accepted grant.

The rate and the mode are sampled only at interval boundaries. A new reading or a new mode select therefore changes the request spacing starting with the next interval.

Top module: `thermal_refresh_sched`

## Requirements
- R1: After reset, in all-bank mode and outside the high-temperature range, the cycles between consecutive request rises equal `base_interval`, as long as every request is granted when it is raised.
- R2: A valid reading strictly greater than 85 enters the high-temperature range, and a reading of exactly 85 does not. The fast interval (`base_interval` shifted right by one) applies from the next interval boundary.
- R3: Once in the high-temperature range, readings of 83, 84 and 85 keep the fast rate. Only a valid reading strictly below 83 returns to the base rate, starting at the next boundary.
- R4: `over_temp` is registered from each valid reading and appears one cycle after it. It is 1 exactly when that reading is strictly greater than 95. The fast rate is kept while it is raised.
- R5: When `same_bank` is 1 at a boundary, the next interval is divided by 4 (the bank count), `ref_type` becomes 1, and `ref_bank` steps 0,1,2,3,0 on each accepted grant. When `same_bank` is 0, `ref_type` is 0 and `ref_bank` holds its value.
- R6: A raised request stays raised until granted. Missed intervals are counted up to 8, and the count saturates there. After the count saturates, exactly 8 consecutive granted cycles drain it, and the request then falls.
- R7: A grant while `ref_req` is 0 changes neither the request debt nor `ref_bank`.
- R8: During and just after reset, `ref_req`, `ref_type`, `ref_bank` and `over_temp` are all 0, and the base rate is selected.

Encodings: `ref_type` 0 = all-bank and 1 = same-bank. Temperature is an unsigned integer in °C. `base_interval` must be at least 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_interval | input | CNT_W (24) | Cycle count of one interval in the normal range, all-bank mode |
| temp_data | input | TEMP_W (8) | Case temperature reading, °C |
| temp_valid | input | 1 | Strobe marking `temp_data` as a new reading |
| same_bank | input | 1 | Mode select, 1 = same-bank refresh rotation |
| ref_grant | input | 1 | Ready from the arbiter, accepts the current request |
| ref_req | output | 1 | Valid, a refresh is owed |
| ref_type | output | 1 | Kind of refresh owed: 0 all-bank, 1 same-bank |
| ref_bank | output | BANK_W (2) | Bank index targeted in same-bank mode |
| over_temp | output | 1 | Latest reading above the rated maximum |

## Verification
The interval timer raises a tick on a clock edge, and `ref_req` is visible from the following falling edge. The bench therefore measures spacing from one sampled rise of `ref_req` to the next, counting falling edges. Because a new temperature or mode takes effect only at a boundary, one measured interval is discarded after each change before the expected spacing is compared. `over_temp` is due one edge after the strobe and is read at the falling edge that follows that edge. Each scoreboard item is compared at the falling edge before the handshake edge, while `ref_type` and `ref_bank` still show the request being granted.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic {
    REF_ALL  = 1'b0,
    REF_SAME = 1'b1
  } ref_kind_e;
endpackage

// File: rtl/rfs_thermal.sv
module rfs_thermal #(
  parameter int TEMP_W     = 8,
  parameter int HOT_ENTER  = 85,
  parameter int HOT_EXIT   = 83,
  parameter int ALARM_OVER = 95
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              temp_vld_i,
  output logic              hot_o,
  output logic              alarm_o
);
  localparam logic [TEMP_W-1:0] EnterT = TEMP_W'(HOT_ENTER);
  localparam logic [TEMP_W-1:0] ExitT  = TEMP_W'(HOT_EXIT);
  localparam logic [TEMP_W-1:0] AlarmT = TEMP_W'(ALARM_OVER);

  logic hot_q, alarm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hot_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else if (temp_vld_i) begin
      alarm_q <= (temp_i > AlarmT);
      if (temp_i > EnterT)     hot_q <= 1'b1;
      else if (temp_i < ExitT) hot_q <= 1'b0;
    end
  end

  assign hot_o   = hot_q;
  assign alarm_o = alarm_q;

  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_vld_i && temp_i >= ExitT && temp_i <= EnterT) |=> $stable(hot_q)); // R3
  AST_ALARM_KEEPS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |-> hot_q); // R4
  AST_ALARM_NEEDS_READING: assert property (@(posedge clk) disable iff (!rst_n)
    !temp_vld_i |=> $stable(alarm_q)); // R4
endmodule

// File: rtl/rfs_pacer.sv
module rfs_pacer #(
  parameter int CNT_W     = 24,
  parameter int NUM_BANKS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] base_i,
  input  logic             hot_i,
  input  logic             same_bank_i,
  output logic             tick_o,
  output logic             fast_o,
  output logic             same_o
);
  localparam int BankShift = $clog2(NUM_BANKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             fast_q, same_q;
  int unsigned      shamt;

  always_comb begin
    shamt = (fast_q ? 1 : 0) + (same_q ? BankShift : 0);
    lim   = base_i >> shamt;
    tick_o = (lim <= CNT_W'(1)) || (cnt_q >= lim - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fast_q <= 1'b0;
      same_q <= 1'b0;
    end else if (tick_o) begin
      cnt_q  <= '0;
      fast_q <= hot_i;
      same_q <= same_bank_i;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign fast_o = fast_q;
  assign same_o = same_q;

  AST_RATE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> ($stable(fast_q) && $stable(same_q))); // R2
endmodule

// File: rtl/rfs_ledger.sv
module rfs_ledger #(
  parameter int NUM_BANKS = 4,
  parameter int DEBT_MAX  = 8,
  localparam int BankW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             same_i,
  input  logic             grant_i,
  output logic             req_o,
  output logic [BankW-1:0] bank_o
);
  localparam int DebtW = $clog2(DEBT_MAX + 1);
  localparam logic [DebtW-1:0] DebtTop = DebtW'(DEBT_MAX);

  logic [DebtW-1:0] debt_q;
  logic [BankW-1:0] bank_q, bank_nx;
  logic             take;

  assign req_o = (debt_q != '0);
  assign take  = req_o && grant_i;

  generate
    if ((1 << BankW) == NUM_BANKS) begin : g_pow2_wrap
      assign bank_nx = bank_q + BankW'(1);
    end else begin : g_cmp_wrap
      assign bank_nx = (bank_q == BankW'(NUM_BANKS - 1)) ? '0 : bank_q + BankW'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      debt_q <= '0;
      bank_q <= '0;
    end else begin
      if (tick_i && !take) begin
        if (debt_q != DebtTop) debt_q <= debt_q + DebtW'(1);
      end else if (take && !tick_i) begin
        debt_q <= debt_q - DebtW'(1);
      end
      if (take && same_i) bank_q <= bank_nx;
    end
  end

  assign bank_o = bank_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    debt_q <= DebtTop); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !grant_i) |=> req_o); // R6
  AST_BANK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(bank_q)); // R7
  AST_ALLBANK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !same_i) |=> $stable(bank_q)); // R5
endmodule

// File: rtl/thermal_refresh_sched.sv
module thermal_refresh_sched #(
  parameter int CNT_W      = 24,
  parameter int TEMP_W     = 8,
  parameter int NUM_BANKS  = 4,
  parameter int DEBT_MAX   = 8,
  parameter int HOT_ENTER  = 85,
  parameter int HOT_EXIT   = 83,
  parameter int ALARM_OVER = 95,
  localparam int BankW     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  base_interval,
  input  logic [TEMP_W-1:0] temp_data,
  input  logic              temp_valid,
  input  logic              same_bank,
  input  logic              ref_grant,
  output logic              ref_req,
  output logic              ref_type,
  output logic [BankW-1:0]  ref_bank,
  output logic              over_temp
);
  import refresh_pkg::*;

  logic      hot, tick, fast, same_q;
  ref_kind_e kind;

  rfs_thermal #(
    .TEMP_W(TEMP_W), .HOT_ENTER(HOT_ENTER), .HOT_EXIT(HOT_EXIT), .ALARM_OVER(ALARM_OVER)
  ) u_thermal (
    .clk(clk), .rst_n(rst_n), .temp_i(temp_data), .temp_vld_i(temp_valid),
    .hot_o(hot), .alarm_o(over_temp)
  );

  rfs_pacer #(.CNT_W(CNT_W), .NUM_BANKS(NUM_BANKS)) u_pacer (
    .clk(clk), .rst_n(rst_n), .base_i(base_interval), .hot_i(hot),
    .same_bank_i(same_bank), .tick_o(tick), .fast_o(fast), .same_o(same_q)
  );

  rfs_ledger #(.NUM_BANKS(NUM_BANKS), .DEBT_MAX(DEBT_MAX)) u_ledger (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .same_i(same_q),
    .grant_i(ref_grant), .req_o(ref_req), .bank_o(ref_bank)
  );

  assign kind     = same_q ? REF_SAME : REF_ALL;
  assign ref_type = kind;

  AST_ALARM_FAST_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (over_temp && tick) |=> fast); // R4
endmodule

// File: tb/thermal_refresh_sched_bench.sv
module thermal_refresh_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] base_interval = 24'd64;
  logic [7:0]  temp_data = 8'd40;
  logic        temp_valid = 1'b0;
  logic        same_bank = 1'b0;
  logic        ref_grant = 1'b1;
  logic        ref_req, ref_type, over_temp;
  logic [1:0]  ref_bank;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit sb_on = 1'b0;
  logic [2:0] exp_q[$];

  always #2 clk = ~clk;

  thermal_refresh_sched u_thermal_refresh_sched (
    .clk(clk), .rst_n(rst_n), .base_interval(base_interval), .temp_data(temp_data),
    .temp_valid(temp_valid), .same_bank(same_bank), .ref_grant(ref_grant),
    .ref_req(ref_req), .ref_type(ref_type), .ref_bank(ref_bank), .over_temp(over_temp)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_temp(input int t);
    @(negedge clk);
    temp_data = 8'(t);
    temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic measure(output int n);
    do @(negedge clk); while (!ref_req);
    n = 0;
    do begin @(negedge clk); n++; end while (!ref_req);
  endtask

  task automatic expect_period(input string req, input int exp);
    int n;
    measure(n);
    measure(n);
    check(n == exp, req, n, exp);
  endtask

  task automatic push_items(input bit kind, input int start, input int count);
    for (int i = 0; i < count; i++)
      exp_q.push_back({kind, 2'((kind ? start + i : start) % 4)});
    sb_on = 1'b1;
    wait (exp_q.size() == 0);
    sb_on = 1'b0;
  endtask

  // scoreboard monitor: compares each accepted request with the next expected item
  always @(negedge clk) begin
    if (sb_on && ref_req && ref_grant && exp_q.size() > 0) begin
      logic [2:0] e;
      e = exp_q.pop_front();
      check({ref_type, ref_bank} == e, "R5 type/bank", {ref_type, ref_bank}, e);
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(ref_req == 0 && ref_bank == 0 && ref_type == 0 && over_temp == 0,
          "R8 reset outputs", {ref_req, ref_type, ref_bank, over_temp}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(ref_req == 0 && over_temp == 0, "R8 after release", {ref_req, over_temp}, 0);

    expect_period("R1 base interval", 64);
    send_temp(85);
    expect_period("R2 reading 85 stays slow", 64);
    send_temp(86);
    expect_period("R2 reading 86 fast", 32);
    send_temp(84);
    expect_period("R3 reading 84 keeps fast", 32);
    send_temp(83);
    expect_period("R3 reading 83 keeps fast", 32);
    send_temp(82);
    expect_period("R3 reading 82 back to slow", 64);

    send_temp(96);
    check(over_temp == 1, "R4 alarm on 96", over_temp, 1);
    expect_period("R4 fast kept under alarm", 32);
    send_temp(95);
    check(over_temp == 0, "R4 alarm off at 95", over_temp, 0);
    send_temp(70);
    check(over_temp == 0, "R4 alarm off at 70", over_temp, 0);

    same_bank = 1'b1;
    expect_period("R5 same-bank slow interval", 16);
    @(negedge clk);
    push_items(1'b1, ref_bank, 6);
    send_temp(90);
    expect_period("R5 same-bank fast interval", 8);
    @(negedge clk);
    push_items(1'b1, ref_bank, 5);
    same_bank = 1'b0;
    expect_period("R5 all-bank fast interval", 32);
    @(negedge clk);
    push_items(1'b0, ref_bank, 3);
    send_temp(60);
    expect_period("R1 slow restored", 64);

    // R7: grant held high while idle leaves bank and debt alone
    @(negedge clk);
    n = ref_bank;
    repeat (20) @(negedge clk);
    check(ref_bank == n && ref_req == 0, "R7 idle grant ignored", ref_bank, n);

    // R6: postponed debt saturates at 8
    base_interval = 24'd1024;
    measure(n);
    measure(n);
    check(n == 1024, "R1 base 1024", n, 1024);
    ref_grant = 1'b0;
    repeat (10 * 1024 + 20) @(negedge clk);
    check(ref_req == 1, "R6 request held", ref_req, 1);
    ref_grant = 1'b1;
    n = 0;
    while (ref_req) begin n++; @(negedge clk); end
    check(n == 8, "R6 debt drained", n, 8);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule